// File: doc/BRIEF.md
# Gated AXI Framebuffer Writer

This block takes 16-bit pixels from a rasterizer on a valid/ready stream and stores them in external memory as fixed 32-byte AXI4 write bursts. Burst addresses start at a byte base held in a register. Each later burst sits 32 bytes above the one before it. The block sends nothing to memory until a host sets the arm bit. A canary mode writes only the first 32-byte line. This lets bring-up software confirm that the memory path and the address are correct before it allows a whole 8 KiB frame.

The host reaches a small 32-bit register file through a plain write strobe and an address. Reads are combinational on the address. The status register reports idle state and two sticky flags: one for an error write response and one for a FIFO overflow. Two counters report completed bursts and bytes written. The pixel input is never back-pressured, so `pix_ready` stays high. A pixel offered while the internal FIFO is full is lost, and the loss is recorded in the overflow flag. Only one burst is ever outstanding on the memory side.

Top module: `fbw_writer`

## Requirements
- R1: The control register at offset 0x00 has arm in bit 0 (1 permits writes) and canary in bit 1 (1 limits the frame to one burst). It reads 0x2 after reset.
- R2: While arm is 0, no write address is issued and pixels offered on the stream are discarded. They never appear in a later burst.
- R3: The base register at offset 0x04 resets to 0x8000_0000. Burst n of a frame is addressed at base + 32·n.
- R4: Every burst uses AWLEN=3, AWSIZE=3 and AWBURST=1 (INCR). It has four 64-bit beats with WSTRB=0xFF, and WLAST is set on the fourth beat only.
- R5: Pixels are packed little-endian. Pixel k of a burst occupies bits [16·(k mod 4)+15 : 16·(k mod 4)] of beat k/4, so the value 0x8200 lands in memory as bytes 00, 82.
- R6: With canary 0 a frame is 256 bursts (8 KiB). With canary 1 exactly one burst is written.
- R7: At most one burst is outstanding. A new address is issued only after the previous write response has been accepted.
- R8: The status register at offset 0x08 has idle in bit 0. Bit 1 is a sticky flag that sets on any write response other than OKAY (0). Bit 2 is a sticky FIFO-overflow flag.
- R9: The byte counter at offset 0x0C and the burst counter at offset 0x10 advance by 32 and by 1 on each accepted write response. They clear only at reset.
- R10: `pix_ready` is always 1. A pixel offered while the 32-entry FIFO is full is dropped and sets the overflow flag.
- R11: A rising edge of arm flushes the FIFO and starts a frame at offset 0. After the frame or canary line ends, the block is idle and writes nothing more until arm rises again.
- R12: Register writes to offsets 0x08, 0x0C and 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready (constant 1) |
| pix_data | input | 16 | Pixel value |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Burst byte address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 64 | Write data beat |
| m_wstrb | output | 8 | Byte strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
Canary frames are driven with a constant colour, with rising ramps that have different strides, and with a base near the top of the address space. This separates lane-order mistakes from address-arithmetic mistakes. A full frame fed with the pixel index as its value exposes any skipped, repeated or misplaced burst among the 256. A stalled address channel with a long pixel run forces overflow and shows which pixels survive. Pixels sent while disarmed, and pixels left in the FIFO from an earlier frame, are then shown to be absent from the next burst. An error response followed by a clean one shows that the error flag is sticky rather than tracking the latest response.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_BASE   = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_BYTES  = 8'h0C;
  localparam logic [7:0] OFS_BURSTS = 8'h10;

  localparam logic [1:0]        CTRL_RESET = 2'b10;
  localparam logic [ADDR_W-1:0] BASE_RESET = 32'h8000_0000;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } wr_state_e;
endpackage

// File: rtl/fbw_pix_fifo.sv
// Pixel FIFO: single push, LANES-wide pop. DEPTH must be a power of two.
module fbw_pix_fifo #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   push,
  input  logic [PIX_W-1:0]       push_data,
  input  logic                   pop,
  output logic [CNT_W-1:0]       count,
  output logic [LANES*PIX_W-1:0] pop_data,
  output logic                   overflow
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wr_ptr, rd_ptr;
  logic             full;

  assign count    = wr_ptr - rd_ptr;
  assign full     = (count == CNT_W'(DEPTH));
  assign overflow = push && full;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop)           rd_ptr <= rd_ptr + CNT_W'(LANES);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wr_ptr[PTR_W-1:0]] <= push_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr[PTR_W-1:0] + PTR_W'(g);
    assign pop_data[g*PIX_W +: PIX_W] = mem[idx];
  end
endmodule

// File: rtl/fbw_regs.sv
// Host register file: control, base, status and counters.
module fbw_regs
  import fbw_pkg::*;
#(
  parameter int BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              arm,
  output logic              canary,
  output logic [ADDR_W-1:0] base,
  output logic              err_flag,
  output logic              ovf_flag,
  input  logic              idle,
  input  logic              burst_done,
  input  logic              resp_err,
  input  logic              overflow
);
  logic [1:0]       ctrl_q;
  logic [REG_W-1:0] bytes_q, bursts_q;

  assign arm    = ctrl_q[0];
  assign canary = ctrl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      base     <= BASE_RESET;
      bytes_q  <= '0;
      bursts_q <= '0;
      err_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[1:0];
      if (reg_wr && reg_addr == OFS_BASE) base   <= reg_wdata;
      if (burst_done) begin
        bytes_q  <= bytes_q + REG_W'(BURST_BYTES);
        bursts_q <= bursts_q + 1'b1;
      end
      if (resp_err) err_flag <= 1'b1;
      if (overflow) ovf_flag <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:   reg_rdata = {{(REG_W-2){1'b0}}, ctrl_q};
      OFS_BASE:   reg_rdata = base;
      OFS_STATUS: reg_rdata = {{(REG_W-3){1'b0}}, ovf_flag, err_flag, idle};
      OFS_BYTES:  reg_rdata = bytes_q;
      OFS_BURSTS: reg_rdata = bursts_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbw_burst_ctrl.sv
// Frame sequencer: one outstanding burst, gated by arm.
module fbw_burst_ctrl
  import fbw_pkg::*;
#(
  parameter int FRAME_BURSTS = 256,
  parameter int BEATS        = 4,
  parameter int BURST_PIX    = 16,
  parameter int BURST_BYTES  = 32,
  parameter int CNT_W        = 6,
  localparam int IDX_W  = $clog2(FRAME_BURSTS),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int SH     = $clog2(BURST_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              canary,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              flush,
  output logic              accept_en,
  output logic              pop,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              burst_done,
  output logic              resp_err,
  output logic              idle
);
  wr_state_e         state, state_nx;
  logic              arm_d;
  logic [IDX_W-1:0]  idx;
  logic [BEAT_W-1:0] beat;
  logic              last_burst;

  assign flush      = arm && !arm_d && (state == ST_IDLE);
  assign last_burst = canary || (idx == IDX_W'(FRAME_BURSTS - 1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (flush) state_nx = ST_FILL;
      ST_FILL: begin
        if (!arm)                                state_nx = ST_IDLE;
        else if (fifo_count >= CNT_W'(BURST_PIX)) state_nx = ST_ADDR;
      end
      ST_ADDR: if (awready) state_nx = ST_DATA;
      ST_DATA: if (wready && beat == BEAT_W'(BEATS - 1)) state_nx = ST_RESP;
      ST_RESP: if (bvalid) state_nx = (!arm || last_burst) ? ST_IDLE : ST_FILL;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      arm_d <= 1'b0;
      idx   <= '0;
      beat  <= '0;
    end else begin
      state <= state_nx;
      arm_d <= arm;
      if (flush)                         idx  <= '0;
      else if (state == ST_RESP && bvalid) idx <= idx + 1'b1;
      if (state == ST_DATA && wready)    beat <= beat + 1'b1;
    end
  end

  assign accept_en  = (state != ST_IDLE);
  assign idle       = (state == ST_IDLE);
  assign awvalid    = (state == ST_ADDR);
  assign awaddr     = base + (ADDR_W'(idx) << SH);
  assign wvalid     = (state == ST_DATA);
  assign wlast      = (beat == BEAT_W'(BEATS - 1));
  assign pop        = wvalid && wready;
  assign bready     = (state == ST_RESP);
  assign burst_done = bvalid && bready;
  assign resp_err   = burst_done && (bresp != RESP_OKAY);
endmodule

// File: rtl/fbw_writer.sv
// Top: pixel stream in, gated AXI4 write bursts out.
module fbw_writer
  import fbw_pkg::*;
#(
  parameter int PIX_W       = 16,
  parameter int DATA_W      = 64,
  parameter int FIFO_DEPTH  = 32,
  parameter int BURST_BYTES = 32,
  parameter int FRAME_BYTES = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                pix_valid,
  output logic                pix_ready,
  input  logic [PIX_W-1:0]    pix_data,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);
  localparam int LANES        = DATA_W / PIX_W;
  localparam int BEATS        = BURST_BYTES / (DATA_W / 8);
  localparam int BURST_PIX    = BURST_BYTES / (PIX_W / 8);
  localparam int FRAME_BURSTS = FRAME_BYTES / BURST_BYTES;
  localparam int CNT_W        = $clog2(FIFO_DEPTH) + 1;

  logic              arm_w, canary_w, idle_w, err_flag_w, ovf_flag_w;
  logic [ADDR_W-1:0] base_w;
  logic              flush_w, accept_w, pop_w, done_w, resp_err_w, ovf_w;
  logic [CNT_W-1:0]  count_w;

  assign pix_ready = 1'b1;
  assign m_awlen   = 8'(BEATS - 1);
  assign m_awsize  = 3'($clog2(DATA_W / 8));
  assign m_awburst = BURST_INCR;
  assign m_wstrb   = '1;

  fbw_regs #(.BURST_BYTES(BURST_BYTES)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .arm(arm_w), .canary(canary_w), .base(base_w),
    .err_flag(err_flag_w), .ovf_flag(ovf_flag_w),
    .idle(idle_w), .burst_done(done_w), .resp_err(resp_err_w), .overflow(ovf_w)
  );

  fbw_pix_fifo #(.PIX_W(PIX_W), .DEPTH(FIFO_DEPTH), .LANES(LANES)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_w),
    .push(pix_valid && accept_w), .push_data(pix_data),
    .pop(pop_w), .count(count_w), .pop_data(m_wdata), .overflow(ovf_w)
  );

  fbw_burst_ctrl #(
    .FRAME_BURSTS(FRAME_BURSTS), .BEATS(BEATS), .BURST_PIX(BURST_PIX),
    .BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .canary(canary_w), .base(base_w),
    .fifo_count(count_w), .flush(flush_w), .accept_en(accept_w), .pop(pop_w),
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
    .wvalid(m_wvalid), .wready(m_wready), .wlast(m_wlast),
    .bvalid(m_bvalid), .bready(m_bready), .bresp(m_bresp),
    .burst_done(done_w), .resp_err(resp_err_w), .idle(idle_w)
  );
endmodule

// File: rtl/fbw_writer_chk.sv
// Protocol and status checker, bound into fbw_writer.
module fbw_writer_chk #(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic err_flag,
  input logic ovf_flag,
  input logic awvalid,
  input logic awready,
  input logic wvalid,
  input logic wready,
  input logic wlast,
  input logic bvalid,
  input logic bready
);
  logic              outstanding;
  logic [BEAT_W-1:0] beat_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      beat_c      <= '0;
    end else begin
      if (awvalid && awready)     outstanding <= 1'b1;
      else if (bvalid && bready)  outstanding <= 1'b0;
      if (wvalid && wready)       beat_c <= beat_c + 1'b1;
    end
  end

  AST_AW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $past(arm));                                     // R2
  AST_AW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid);                                   // R4
  AST_WLAST_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wlast == (beat_c == BEAT_W'(BEATS - 1))));             // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> !outstanding);                                          // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_flag) |-> err_flag);                                      // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_flag) |-> ovf_flag);                                      // R10
endmodule

bind fbw_writer fbw_writer_chk #(.BEATS(BEATS)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm_w), .err_flag(err_flag_w), .ovf_flag(ovf_flag_w),
  .awvalid(m_awvalid), .awready(m_awready), .wvalid(m_wvalid), .wready(m_wready),
  .wlast(m_wlast), .bvalid(m_bvalid), .bready(m_bready)
);

// File: tb/fbw_writer_tb.sv
`timescale 1ns/1ps
module fbw_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_data = '0;
  logic        m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bready;
  logic [31:0] m_awaddr;
  logic [7:0]  m_awlen, m_wstrb;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic [63:0] m_wdata;
  logic        m_bvalid;
  logic [1:0]  m_bresp;

  always #2.5 clk = ~clk;

  fbw_writer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
    .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
  );

  // ---- memory-side responder and logger ----
  logic        aw_block = 1'b0;
  logic [1:0]  resp_next = 2'b00;
  logic [31:0] aw_log [512];
  logic [63:0] w_log  [2048];
  int          aw_cnt, w_cnt, fmt_bad, ovl_bad;
  logic        slv_out;

  assign m_awready = !aw_block;
  assign m_wready  = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bvalid <= 1'b0; m_bresp <= 2'b00;
      aw_cnt <= 0; w_cnt <= 0; fmt_bad <= 0; ovl_bad <= 0; slv_out <= 1'b0;
    end else begin
      if (m_awvalid && m_awready) begin
        aw_log[aw_cnt] <= m_awaddr;
        aw_cnt <= aw_cnt + 1;
        slv_out <= 1'b1;
        if (slv_out) ovl_bad <= ovl_bad + 1;
        if (m_awlen != 8'd3 || m_awsize != 3'd3 || m_awburst != 2'd1) fmt_bad <= fmt_bad + 1;
      end else if (m_bvalid && m_bready) slv_out <= 1'b0;
      if (m_wvalid && m_wready) begin
        w_log[w_cnt] <= m_wdata;
        w_cnt <= w_cnt + 1;
        if (m_wstrb != 8'hFF || m_wlast != ((w_cnt % 4) == 3)) fmt_bad <= fmt_bad + 1;
      end
      if (m_wvalid && m_wready && m_wlast) begin
        m_bvalid <= 1'b1; m_bresp <= resp_next;
      end else if (m_bvalid && m_bready) m_bvalid <= 1'b0;
    end
  end

  // ---- bookkeeping ----
  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  int  exp_bursts = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input int n, input logic [15:0] start, input logic [15:0] step);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_valid = 1'b1; pix_data = start + 16'(i) * step;
    end
    @(negedge clk); pix_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h0;
    while (s[0] == 1'b0) rd(8'h08, s);
  endtask

  task automatic arm_frame(input logic [31:0] ctrl);
    wr(8'h00, 32'h2);
    wr(8'h00, ctrl);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] beat_of(input logic [15:0] start, input logic [15:0] step, input int b);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[16*k +: 16] = start + 16'(4*b + k) * step;
    return v;
  endfunction

  // Check one canary burst: address, four beats (R3, R5) and counters (R9).
  task automatic check_canary(input string tag, input int aw0, input int w0,
                              input logic [31:0] base, input logic [15:0] st, input logic [15:0] sp);
    logic [31:0] v;
    exp_bursts++;
    chk(aw_cnt == aw0 + 1, {tag, " R6 one burst"}, 64'(aw_cnt), 64'(aw0 + 1));
    chk(aw_log[aw0] == base, {tag, " R3 address"}, 64'(aw_log[aw0]), 64'(base));
    for (int b = 0; b < 4; b++)
      chk(w_log[w0 + b] == beat_of(st, sp, b), {tag, " R5 beat data"}, w_log[w0 + b], beat_of(st, sp, b));
    rd(8'h10, v); chk(v == 32'(exp_bursts), {tag, " R9 burst count"}, 64'(v), 64'(exp_bursts));
    rd(8'h0C, v); chk(v == 32'(32 * exp_bursts), {tag, " R9 byte count"}, 64'(v), 64'(32 * exp_bursts));
  endtask

  // {base, first pixel, pixel step}
  localparam logic [63:0] VEC [4] = '{
    {32'h8000_0000, 16'h8200, 16'h0000},
    {32'h1000_0040, 16'h0001, 16'h0001},
    {32'hFFFF_FFE0, 16'hFFF0, 16'h0003},
    {32'h0000_0020, 16'hA5A5, 16'h1111}
  };

  initial begin
    logic [31:0] v;
    int aw0, w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R1 R3 R8 R9 R10
    rd(8'h00, v); chk(v == 32'h2, "R1 ctrl reset", 64'(v), 64'h2);
    rd(8'h04, v); chk(v == 32'h8000_0000, "R3 base reset", 64'(v), 64'h8000_0000);
    rd(8'h08, v); chk(v == 32'h1, "R8 status reset idle", 64'(v), 64'h1);
    rd(8'h0C, v); chk(v == 0, "R9 bytes reset", 64'(v), 64'h0);
    rd(8'h10, v); chk(v == 0, "R9 bursts reset", 64'(v), 64'h0);
    chk(pix_ready == 1'b1, "R10 ready high", 64'(pix_ready), 64'h1);

    // Table of canary frames
    for (int i = 0; i < 4; i++) begin
      wr(8'h04, VEC[i][63:32]);
      aw0 = aw_cnt; w0 = w_cnt;
      arm_frame(32'h3);
      push(16, VEC[i][31:16], VEC[i][15:0]);
      wait_idle();
      check_canary("table", aw0, w0, VEC[i][63:32], VEC[i][31:16], VEC[i][15:0]);
      push(16, 16'h7777, 16'h0001);
      repeat (10) @(negedge clk);
      chk(aw_cnt == aw0 + 1, "R11 no write after canary line", 64'(aw_cnt), 64'(aw0 + 1));
      wr(8'h00, 32'h2);
    end

    // R2: disarmed pixels never written
    wr(8'h04, 32'h8000_0000);
    aw0 = aw_cnt; w0 = w_cnt;
    push(16, 16'hDEAD, 16'h0000);
    repeat (20) @(negedge clk);
    chk(aw_cnt == aw0, "R2 no address while disarmed", 64'(aw_cnt), 64'(aw0));
    arm_frame(32'h3);
    push(16, 16'h4000, 16'h0001);
    wait_idle();
    check_canary("R2 after disarm", aw0, w0, 32'h8000_0000, 16'h4000, 16'h0001);

    // R10: overflow with a stalled address channel
    rd(8'h08, v); chk(v[2] == 1'b0, "R10 no overflow yet", 64'(v[2]), 64'h0);
    aw0 = aw_cnt; w0 = w_cnt;
    aw_block = 1'b1;
    arm_frame(32'h3);
    push(40, 16'h3000, 16'h0001);
    rd(8'h08, v); chk(v[2] == 1'b1, "R10 overflow flag set", 64'(v[2]), 64'h1);
    aw_block = 1'b0;
    wait_idle();
    check_canary("R10 survivors", aw0, w0, 32'h8000_0000, 16'h3000, 16'h0001);

    // R11: leftover FIFO contents flushed by the next arm edge
    aw0 = aw_cnt; w0 = w_cnt;
    arm_frame(32'h3);
    push(16, 16'h5100, 16'h0002);
    wait_idle();
    check_canary("R11 flush", aw0, w0, 32'h8000_0000, 16'h5100, 16'h0002);
    rd(8'h08, v); chk(v[2] == 1'b1, "R10 overflow sticky", 64'(v[2]), 64'h1);

    // R8: error response is sticky
    resp_next = 2'b10;
    aw0 = aw_cnt; w0 = w_cnt;
    arm_frame(32'h3);
    push(16, 16'h0600, 16'h0001);
    wait_idle();
    check_canary("R8 err burst", aw0, w0, 32'h8000_0000, 16'h0600, 16'h0001);
    rd(8'h08, v); chk(v[1] == 1'b1, "R8 error flag set", 64'(v[1]), 64'h1);
    resp_next = 2'b00;
    aw0 = aw_cnt; w0 = w_cnt;
    arm_frame(32'h3);
    push(16, 16'h0700, 16'h0001);
    wait_idle();
    check_canary("R8 ok burst", aw0, w0, 32'h8000_0000, 16'h0700, 16'h0001);
    rd(8'h08, v); chk(v[1] == 1'b1, "R8 error flag sticky", 64'(v[1]), 64'h1);

    // R12: writes to read-only offsets ignored
    wr(8'h10, 32'h0); wr(8'h0C, 32'h0); wr(8'h08, 32'h0);
    rd(8'h10, v); chk(v == 32'(exp_bursts), "R12 bursts unchanged", 64'(v), 64'(exp_bursts));
    rd(8'h0C, v); chk(v == 32'(32 * exp_bursts), "R12 bytes unchanged", 64'(v), 64'(32 * exp_bursts));
    rd(8'h08, v); chk(v == 32'h7, "R12 status unchanged", 64'(v), 64'h7);

    // R6: full frame of 256 bursts
    aw0 = aw_cnt; w0 = w_cnt;
    arm_frame(32'h1);
    push(4096, 16'h0000, 16'h0001);
    wait_idle();
    chk(aw_cnt == aw0 + 256, "R6 full frame burst count", 64'(aw_cnt), 64'(aw0 + 256));
    begin
      int bad_a, bad_d;
      bad_a = 0; bad_d = 0;
      for (int n = 0; n < 256; n++)
        if (aw_log[aw0 + n] != 32'h8000_0000 + 32'(32 * n)) bad_a++;
      for (int b = 0; b < 1024; b++)
        if (w_log[w0 + b] != beat_of(16'h0000, 16'h0001, b)) bad_d++;
      chk(bad_a == 0, "R3 full frame addresses", 64'(bad_a), 64'h0);
      chk(bad_d == 0, "R5 full frame data", 64'(bad_d), 64'h0);
    end
    exp_bursts += 256;
    rd(8'h10, v); chk(v == 32'(exp_bursts), "R9 bursts after frame", 64'(v), 64'(exp_bursts));
    rd(8'h0C, v); chk(v == 32'(32 * exp_bursts), "R9 bytes after frame", 64'(v), 64'(32 * exp_bursts));
    push(16, 16'h9999, 16'h0000);
    repeat (10) @(negedge clk);
    chk(aw_cnt == aw0 + 256, "R11 idle after frame", 64'(aw_cnt), 64'(aw0 + 256));
    rd(8'h00, v); chk(v == 32'h1, "R1 ctrl readback", 64'(v), 64'h1);

    chk(fmt_bad == 0, "R4 burst format", 64'(fmt_bad), 64'h0);
    chk(ovl_bad == 0, "R7 single outstanding", 64'(ovl_bad), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule